// File: doc/BRIEF.md
# Flash Execute-in-Place Read Window

The block turns bus reads from a memory-mapped window into serial flash reads. Software first loads a stored read sequence: one opcode byte, an address width of three or four bytes, and a count of turnaround clocks. After that, every read request on the window bus port runs the same sequence. The request's byte offset is placed in the address slot, and data-in continues until the requested number of bytes has arrived. The block then releases chip select and returns to idle.

The window bus port is separate from the register port that software uses for its own transactions. The block sees that other path through two inputs. A start pulse means a register-driven transaction has replaced the stored sequence, so software must reload it before the window can be used again. A busy level holds off new window reads until that transaction has finished. The serial link is single-lane. The serial clock runs at half the system clock, idles low, and the block launches data on the falling edge and samples on the rising edge.

Top module: `xip_read_window`

## Requirements
- R1: Each window read begins by driving the stored 8-bit opcode on spi_mosi, most significant bit first, with spi_mosi_oe high.
- R2: Directly after the opcode come the address bits, most significant bit first, with spi_mosi_oe high. The address is the request's win_addr zero-extended to 32 bits. When cfg_addr4 was 1 at load time, 32 bits are sent. When it was 0, only the low 24 bits are sent.
- R3: After the address, the block gives exactly the stored cfg_dummy serial clocks with spi_mosi_oe low, then starts data-in. A count of 0 goes straight from the address to data.
- R4: win_len holds the byte count minus one. A read returns exactly win_len+1 bytes, each a one-cycle win_rvalid beat carrying the byte assembled with the first received bit as bit 7. win_rlast is high only on the final beat.
- R5: spi_cs_n falls in the cycle after a request is accepted. It rises two cycles after the final data beat. While spi_cs_n is high, spi_sclk is low and no beat is issued.
- R6: While reg_busy is high, no request is accepted (win_ready stays low and spi_cs_n stays high). A held request is accepted once reg_busy falls.
- R7: A reg_start pulse marks the stored sequence invalid. No request is accepted until the next list_load pulse, which captures cfg_opcode, cfg_addr4 and cfg_dummy.
- R8: spi_sclk has a period of two system clocks. spi_mosi changes only at falling serial edges, and spi_miso is sampled at rising serial edges.
- R9: After reset, spi_cs_n is high, spi_sclk is low, win_rvalid is low and win_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| list_load | input | 1 | Capture the read sequence from the cfg_* inputs |
| cfg_opcode | input | 8 | Read opcode to store |
| cfg_addr4 | input | 1 | 1 selects a 4-byte address, 0 selects a 3-byte address |
| cfg_dummy | input | DUMMY_W | Number of turnaround clocks |
| reg_start | input | 1 | A register transaction replaced the stored sequence |
| reg_busy | input | 1 | A register transaction is running |
| win_req | input | 1 | Window read request, held until win_ready |
| win_addr | input | WIN_AW | Byte offset in the window |
| win_len | input | LEN_W | Byte count minus one |
| win_ready | output | 1 | Request accepted this cycle |
| win_rdata | output | 8 | Returned data byte |
| win_rvalid | output | 1 | win_rdata is valid |
| win_rlast | output | 1 | Final byte of the read |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to flash |
| spi_mosi_oe | output | 1 | Output enable for spi_mosi (low means high impedance) |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The bench sweeps both address widths, turnaround counts of 0, 1, 2, 8 and 31, lengths of 1, 2, 3 and 7 bytes, and three offsets. One offset has bits above bit 23 set, which separates correct 24-bit truncation from a full 32-bit send. A model of the flash records every bit it sees and answers with a content pattern that depends on the address. A wrong field order, a wrong bit count, a wrong sampling edge or an off-by-one length therefore shows up as wrong bytes or a wrong edge count. Separate runs hold a request against a busy register path and against an invalidated sequence, to show that it waits and is then served.

// File: rtl/xip_read_window.sv
module xip_read_window #(
  parameter int WIN_AW  = 28,
  parameter int LEN_W   = 14,
  parameter int DUMMY_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               list_load,
  input  logic [7:0]         cfg_opcode,
  input  logic               cfg_addr4,
  input  logic [DUMMY_W-1:0] cfg_dummy,
  input  logic               reg_start,
  input  logic               reg_busy,
  input  logic               win_req,
  input  logic [WIN_AW-1:0]  win_addr,
  input  logic [LEN_W-1:0]   win_len,
  output logic               win_ready,
  output logic [7:0]         win_rdata,
  output logic               win_rvalid,
  output logic               win_rlast,
  output logic               spi_cs_n,
  output logic               spi_sclk,
  output logic               spi_mosi,
  output logic               spi_mosi_oe,
  input  logic               spi_miso
);

  localparam int CW = (DUMMY_W > 6) ? DUMMY_W : 6;

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_ADDR, S_DUMMY, S_DATA, S_END} st_t;

  st_t              st;
  logic [7:0]       op_q;
  logic             a4_q;
  logic [DUMMY_W-1:0] dm_q;
  logic             lv_q;
  logic [39:0]      sr;
  logic [CW-1:0]    cnt;
  logic [CW-1:0]    last;
  logic [LEN_W-1:0] bcnt;
  logic [LEN_W-1:0] len_q;
  logic [6:0]       rx;
  logic             sclk_q;
  logic             cs_q;
  logic [31:0]      a32;

  assign a32         = 32'(win_addr);
  assign win_ready   = (st == S_IDLE) && win_req && lv_q && !reg_busy;
  assign spi_cs_n    = cs_q;
  assign spi_sclk    = sclk_q;
  assign spi_mosi    = sr[39];
  assign spi_mosi_oe = (st == S_CMD) || (st == S_ADDR);

  always_comb begin
    case (st)
      S_CMD:   last = CW'(7);
      S_ADDR:  last = a4_q ? CW'(31) : CW'(23);
      S_DUMMY: last = CW'(dm_q) - CW'(1);
      default: last = CW'(7);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      op_q       <= '0;
      a4_q       <= 1'b0;
      dm_q       <= '0;
      lv_q       <= 1'b0;
      sr         <= '0;
      cnt        <= '0;
      bcnt       <= '0;
      len_q      <= '0;
      rx         <= '0;
      sclk_q     <= 1'b0;
      cs_q       <= 1'b1;
      win_rdata  <= '0;
      win_rvalid <= 1'b0;
      win_rlast  <= 1'b0;
    end else begin
      win_rvalid <= 1'b0;
      win_rlast  <= 1'b0;
      if (reg_start) begin
        lv_q <= 1'b0;
      end else if (list_load) begin
        lv_q <= 1'b1;
        op_q <= cfg_opcode;
        a4_q <= cfg_addr4;
        dm_q <= cfg_dummy;
      end
      case (st)
        S_IDLE: begin
          if (win_ready) begin
            st     <= S_CMD;
            cs_q   <= 1'b0;
            sclk_q <= 1'b0;
            cnt    <= '0;
            bcnt   <= '0;
            len_q  <= win_len;
            sr     <= a4_q ? {op_q, a32} : {op_q, a32[23:0], 8'h00};
          end
        end
        S_END: begin
          cs_q <= 1'b1;
          st   <= S_IDLE;
        end
        default: begin
          sclk_q <= !sclk_q;
          if (!sclk_q) begin
            if (st == S_DATA) begin
              rx <= {rx[5:0], spi_miso};
              if (cnt[2:0] == 3'd7) begin
                win_rvalid <= 1'b1;
                win_rdata  <= {rx, spi_miso};
                win_rlast  <= (bcnt == len_q);
              end
            end
          end else begin
            if (st == S_CMD || st == S_ADDR) sr <= {sr[38:0], 1'b0};
            if (cnt == last) begin
              cnt <= '0;
              case (st)
                S_CMD:   st <= S_ADDR;
                S_ADDR:  st <= (dm_q == '0) ? S_DATA : S_DUMMY;
                S_DUMMY: st <= S_DATA;
                default: begin
                  if (bcnt == len_q) st <= S_END;
                  else bcnt <= bcnt + 1'b1;
                end
              endcase
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
      endcase
    end
  end

  AST_START_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> $past(!reg_busy)); // R6
  AST_START_LIST_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> $past(lv_q)); // R7
  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk); // R5
  AST_BEAT_INSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n)
    win_rvalid |-> !spi_cs_n); // R5
  AST_LAST_IS_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    win_rlast |-> win_rvalid); // R4
  AST_CS_RISE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> $past(win_rlast, 2)); // R5
  AST_ACCEPT_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    win_ready |-> spi_cs_n); // R5

endmodule

// File: tb/test_xip_read_window.sv
module test_xip_read_window;
  localparam int AW = 28, LW = 14, DW = 5;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, list_load, cfg_addr4, reg_start, reg_busy, win_req;
  logic [7:0] cfg_opcode;
  logic [DW-1:0] cfg_dummy;
  logic [AW-1:0] win_addr;
  logic [LW-1:0] win_len;
  logic win_ready, win_rvalid, win_rlast;
  logic [7:0] win_rdata;
  logic spi_cs_n, spi_sclk, spi_mosi, spi_mosi_oe;
  logic spi_miso = 1'b0;

  xip_read_window #(.WIN_AW(AW), .LEN_W(LW), .DUMMY_W(DW)) i_xip_read_window (
    .clk(clk), .rst_n(rst_n), .list_load(list_load), .cfg_opcode(cfg_opcode),
    .cfg_addr4(cfg_addr4), .cfg_dummy(cfg_dummy), .reg_start(reg_start),
    .reg_busy(reg_busy), .win_req(win_req), .win_addr(win_addr), .win_len(win_len),
    .win_ready(win_ready), .win_rdata(win_rdata), .win_rvalid(win_rvalid),
    .win_rlast(win_rlast), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_mosi_oe(spi_mosi_oe), .spi_miso(spi_miso));

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] fbyte(input logic [31:0] x);
    return 8'(x * 7 + (x >> 8) + 32'h3C);
  endfunction

  int abits = 24, dum = 0, rises = 0, oe_bad = 0, per_bad = 0;
  logic [31:0] cur_a = '0;
  logic [39:0] cap = '0;
  time t_prev = 0;

  always @(negedge spi_cs_n) begin
    rises = 0; cap = '0; oe_bad = 0; per_bad = 0;
  end

  always @(posedge spi_sclk) begin
    if (!spi_cs_n) begin
      if (rises > 0 && ($time - t_prev) != 16) per_bad++;
      t_prev = $time;
      if (rises < 8 + abits) begin
        cap = {cap[38:0], spi_mosi};
        if (!spi_mosi_oe) oe_bad++;
      end else if (rises < 8 + abits + dum) begin
        if (spi_mosi_oe) oe_bad++;
      end
      rises++;
    end
  end

  always @(negedge spi_sclk) begin
    int n;
    logic [7:0] b;
    if (!spi_cs_n && rises >= 8 + abits + dum) begin
      n = rises - (8 + abits + dum);
      b = fbyte(cur_a + 32'(n / 8));
      spi_miso = b[7 - (n % 8)];
    end
  end

  logic [7:0] cur_op;
  bit cur_a4;

  task automatic load_list(input logic [7:0] op, input bit a4, input int dm);
    @(negedge clk);
    cfg_opcode = op; cfg_addr4 = a4; cfg_dummy = DW'(dm); list_load = 1'b1;
    @(negedge clk);
    list_load = 1'b0;
    cur_op = op; cur_a4 = a4; abits = a4 ? 32 : 24; dum = dm;
  endtask

  task automatic raise_req(input logic [AW-1:0] a, input int n);
    @(negedge clk);
    win_addr = a; win_len = LW'(n - 1); win_req = 1'b1;
    cur_a = cur_a4 ? 32'(a) : (32'(a) & 32'h00FF_FFFF);
  endtask

  task automatic wait_accept();
    #1;
    while (!win_ready) @(negedge clk);
    @(posedge clk);
    #1 win_req = 1'b0;
  endtask

  task automatic collect(input int n);
    int got = 0, cyc = 0, last_cyc = -100;
    logic [39:0] ex;
    forever begin
      @(negedge clk);
      cyc++;
      if (win_rvalid) begin
        chk(win_rdata == fbyte(cur_a + 32'(got)), "R4", "data byte", win_rdata, fbyte(cur_a + 32'(got)));
        chk(win_rlast == (got == n - 1), "R4", "rlast flag", win_rlast, (got == n - 1));
        got++;
        last_cyc = cyc;
      end
      if (spi_cs_n) break;
    end
    chk(got == n, "R4", "beat count", got, n);
    chk(cyc - last_cyc == 2, "R5", "cs release delay", cyc - last_cyc, 2);
    chk(!spi_sclk, "R5", "sclk idle", spi_sclk, 0);
    ex = cur_a4 ? {cur_op, cur_a} : {8'h00, cur_op, cur_a[23:0]};
    chk((cur_a4 ? cap[39:32] : cap[31:24]) == cur_op, "R1", "opcode bits",
        cur_a4 ? cap[39:32] : cap[31:24], cur_op);
    chk(cap == ex, "R2", "address bits", cap, ex);
    chk(oe_bad == 0, "R3", "oe during phases", oe_bad, 0);
    chk(rises == 8 + abits + dum + 8 * n, "R3", "serial clock count", rises, 8 + abits + dum + 8 * n);
    chk(per_bad == 0, "R8", "sclk period", per_bad, 0);
  endtask

  task automatic do_read(input logic [AW-1:0] a, input int n);
    raise_req(a, n);
    wait_accept();
    collect(n);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int dms[5] = '{0, 1, 2, 8, 31};
    int lens[4] = '{1, 2, 3, 7};
    logic [AW-1:0] adrs[3] = '{28'h0000000, 28'hFFFFFFF, 28'h0A5C3E1};
    bit held;
    rst_n = 1'b0; list_load = 0; cfg_addr4 = 0; reg_start = 0; reg_busy = 0;
    win_req = 0; cfg_opcode = '0; cfg_dummy = '0; win_addr = '0; win_len = '0;
    cur_op = '0; cur_a4 = 0;
    repeat (3) @(negedge clk);
    chk(spi_cs_n && !spi_sclk && !win_rvalid && !win_ready, "R9", "reset outputs",
        {spi_cs_n, spi_sclk, win_rvalid, win_ready}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a4 = 0; a4 < 2; a4++)
      for (int di = 0; di < 5; di++) begin
        load_list(8'h0B ^ 8'(di * 17) ^ 8'(a4 * 64), a4[0], dms[di]);
        for (int li = 0; li < 4; li++)
          for (int ai = 0; ai < 3; ai++)
            do_read(adrs[ai] + AW'(li), lens[li]);
      end

    reg_busy = 1'b1;
    raise_req(28'h0123456, 3);
    held = 1;
    repeat (10) begin
      @(negedge clk);
      if (!spi_cs_n || win_ready) held = 0;
    end
    chk(held, "R6", "held while busy", held, 1);
    reg_busy = 1'b0;
    wait_accept();
    collect(3);

    @(negedge clk);
    reg_start = 1'b1;
    @(negedge clk);
    reg_start = 1'b0;
    raise_req(28'h0300F0F, 2);
    held = 1;
    repeat (10) begin
      @(negedge clk);
      if (!spi_cs_n || win_ready) held = 0;
    end
    chk(held, "R7", "held while list invalid", held, 1);
    load_list(8'h3B, 1'b1, 4);
    wait_accept();
    collect(2);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule